// File: doc/BRIEF.md
# Video Output Byte Formatter

This block turns processed pixels into the 8-bit byte stream that leaves a camera pipeline. Each accepted pixel becomes exactly two bytes. One mode field picks the packing: 4:2:2 luma/chroma, one of four RGB packings, or a raw 10-bit sample split across two bytes. Two swap controls reorder the luma/chroma bytes or exchange the red and blue channels.

Pixels come in on a valid/ready handshake as a 24-bit word, and bytes leave with a valid strobe and a ready input. The configuration is taken at the first pixel of every pixel pair and held for the second pixel, so a pair never mixes two formats. Backpressure on the byte side stalls the pixel handshake. A new pixel is accepted in the same cycle as the previous pixel's second byte leaves, so an unstalled stream carries one byte every cycle.

Top module: `vid_byte_fmt`

## Requirements
- R1: With the mode field at 0, or at one of the unused values 6 and 7, the block is in luma/chroma mode. `px_data[23:16]` is Y, `[15:8]` is Cb and `[7:0]` is Cr. With both swaps off, a pair is sent as Cb(first pixel), Y(first), Cr(second pixel), Y(second).
- R2: In luma/chroma mode with chroma swap on and luma swap off, a pair is sent as Cr(first), Y(first), Cb(second), Y(second).
- R3: In luma/chroma mode with luma swap on, the luma byte of each pixel comes first. Without chroma swap the order is Y, Cb, Y, Cr. With chroma swap also on it is Y, Cr, Y, Cb.
- R4: Mode 1 (16-bit RGB), with R = `px_data[23:16]`, G = `[15:8]` and B = `[7:0]`, sends the first byte {R[7:3], G[7:5]} and the second byte {G[4:2], B[7:3]}.
- R5: Mode 2 (15-bit RGB) sends the first byte {0, R[7:3], G[7:6]} and the second byte {G[5:3], B[7:3]}.
- R6: Mode 3 (12-bit RGB, padding last) sends the first byte {R[7:4], G[7:4]} and the second byte {B[7:4], 0000}.
- R7: Mode 4 (12-bit RGB, padding first) sends the first byte {0000, R[7:4]} and the second byte {G[7:4], B[7:4]}.
- R8: Mode 5 (raw bypass) takes D = `px_data[9:0]` and sends the first byte D[9:2] and the second byte {000000, D[1:0]}. Both swap controls have no effect in this mode.
- R9: In modes 1 to 4, chroma swap exchanges the red and blue channels before packing. Luma swap has no effect in these modes.
- R10: Mode and swap inputs are sampled only when the first pixel of a pair is accepted. Changes made before the second pixel of that pair have no effect on it.
- R11: A stalled output byte stays valid and unchanged until it is taken. While a byte is stalled, `in_ready` is low. After a pixel is accepted, its two bytes follow in order, starting the next cycle.
- R12: After reset `out_valid` is 0, `in_ready` is 1, and the next accepted pixel is the first of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel word valid |
| in_ready | output | 1 | Block can take a pixel this cycle |
| px_data | input | 24 | Pixel word: channel fields or raw sample in bits 9:0 |
| cfg_mode | input | 3 | Packing mode select |
| cfg_swap_chroma | input | 1 | Chroma order swap / red-blue exchange |
| cfg_swap_luma | input | 1 | Luma-first ordering in luma/chroma mode |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_byte | output | 8 | Output byte |

## Verification
Every mode value, including the two unused ones, is swept against all four swap combinations. Each sweep uses pixel words that include all-zeros, all-ones and channel values with distinct bit patterns. This separates a misplaced or truncated bit field from a wrong byte order, and shows whether the swap controls act in the modes where they should and only there. Half of the sweeps run under a pseudo-random output stall, so that held bytes and the blocked pixel handshake are observed. A final sequence changes the configuration in the middle of a pair, and another resets in the middle of a pair, to check when the configuration is sampled and that pair parity is restored.

// File: rtl/vfmt_pkg.sv
`timescale 1ns/1ps
package vfmt_pkg;

    localparam int CH_W    = 8;
    localparam int NUM_CH  = 3;
    localparam int PIX_W   = CH_W * NUM_CH;
    localparam int RAW_W   = 10;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        FMT_YCC     = 3'd0,
        FMT_RGB16   = 3'd1,
        FMT_RGB15   = 3'd2,
        FMT_RGB12_L = 3'd3,
        FMT_RGB12_H = 3'd4,
        FMT_RAW     = 3'd5
    } fmt_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              swap_c;
        logic              swap_l;
    } fmt_cfg_t;

    typedef struct packed {
        logic [CH_W-1:0] c0;
        logic [CH_W-1:0] c1;
        logic [CH_W-1:0] c2;
    } pix_t;

    // Two output bytes of one pixel, first byte in the upper half.
    function automatic logic [WORD_W-1:0] pack_pixel(
        input fmt_cfg_t cfg,
        input logic     odd,
        input pix_t     px
    );
        logic [CH_W-1:0]  r, g, b, y, c;
        logic [RAW_W-1:0] raw;
        logic [WORD_W-1:0] w;
        r   = cfg.swap_c ? px.c2 : px.c0;
        g   = px.c1;
        b   = cfg.swap_c ? px.c0 : px.c2;
        y   = px.c0;
        c   = (odd ^ cfg.swap_c) ? px.c2 : px.c1;
        raw = {px.c1[1:0], px.c2};
        case (cfg.mode)
            FMT_RGB16:   w = {r[7:3], g[7:2], b[7:3]};
            FMT_RGB15:   w = {1'b0, r[7:3], g[7:3], b[7:3]};
            FMT_RGB12_L: w = {r[7:4], g[7:4], b[7:4], 4'h0};
            FMT_RGB12_H: w = {4'h0, r[7:4], g[7:4], b[7:4]};
            FMT_RAW:     w = {raw[RAW_W-1:2], 6'd0, raw[1:0]};
            default:     w = cfg.swap_l ? {y, c} : {c, y};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vfmt_cfg_track.sv
`timescale 1ns/1ps
module vfmt_cfg_track
    import vfmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  fmt_cfg_t cfg_in,
    output fmt_cfg_t cfg_eff,
    output logic     odd
);
    fmt_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            odd   <= 1'b0;
            cfg_q <= '0;
        end else if (accept) begin
            odd <= ~odd;
            if (!odd) cfg_q <= cfg_in;
        end
    end

    // First pixel of a pair uses the live inputs, second uses the snapshot.
    assign cfg_eff = odd ? cfg_q : cfg_in;
endmodule

// File: rtl/vfmt_packer.sv
`timescale 1ns/1ps
module vfmt_packer
    import vfmt_pkg::*;
(
    input  fmt_cfg_t          cfg,
    input  logic              odd,
    input  logic [PIX_W-1:0]  px_in,
    output logic [WORD_W-1:0] word
);
    pix_t px;
    assign px   = pix_t'(px_in);
    assign word = pack_pixel(cfg, odd, px);
endmodule

// File: rtl/vfmt_serializer.sv
`timescale 1ns/1ps
module vfmt_serializer
    import vfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              out_ready,
    output logic              can_load,
    output logic              out_valid,
    output logic              second,
    output logic [BYTE_W-1:0] out_byte
);
    logic              busy;
    logic [WORD_W-1:0] word_q;

    assign can_load  = !busy || (second && out_ready);
    assign out_valid = busy;
    assign out_byte  = second ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            second <= 1'b0;
            word_q <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            second <= 1'b0;
            word_q <= word;
        end else if (busy && out_ready) begin
            if (second) begin
                busy   <= 1'b0;
                second <= 1'b0;
            end else begin
                second <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vid_byte_fmt.sv
`timescale 1ns/1ps
module vid_byte_fmt
    import vfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  px_data,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_swap_chroma,
    input  logic              cfg_swap_luma,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte
);
    fmt_cfg_t          cfg_live;
    fmt_cfg_t          cfg_eff;
    logic              pair_odd;
    logic              accept;
    logic [WORD_W-1:0] packed_word;
    logic              ser_second;

    assign cfg_live = '{mode: cfg_mode, swap_c: cfg_swap_chroma, swap_l: cfg_swap_luma};
    assign accept   = in_valid && in_ready;

    vfmt_cfg_track u_cfg (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .cfg_in  (cfg_live),
        .cfg_eff (cfg_eff),
        .odd     (pair_odd)
    );

    vfmt_packer u_pack (
        .cfg   (cfg_eff),
        .odd   (pair_odd),
        .px_in (px_data),
        .word  (packed_word)
    );

    vfmt_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .word      (packed_word),
        .out_ready (out_ready),
        .can_load  (in_ready),
        .out_valid (out_valid),
        .second    (ser_second),
        .out_byte  (out_byte)
    );
endmodule

// File: rtl/vfmt_checker.sv
`timescale 1ns/1ps
module vfmt_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       second
);
    p_idle_ready_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    p_stall_block_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    p_accept_emits_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && !second);

    p_two_bytes_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !second |=> out_valid && second);
endmodule

bind vid_byte_fmt vfmt_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .second    (ser_second)
);

// File: tb/test_vid_byte_fmt.sv
`timescale 1ns/1ps
module test_vid_byte_fmt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] px_data = '0;
    logic [2:0]  cfg_mode = '0;
    logic        cfg_swap_chroma = 1'b0;
    logic        cfg_swap_luma = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    bp_on  = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    string       tag_force = "";
    bit          m_odd = 0;
    int          m_mode = 0;
    bit          m_sc = 0, m_sl = 0;
    bit          stall_prev = 0;
    logic [7:0]  prev_byte = '0;

    always #5 clk = ~clk;

    vid_byte_fmt i_vid_byte_fmt (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .px_data(px_data), .cfg_mode(cfg_mode), .cfg_swap_chroma(cfg_swap_chroma),
        .cfg_swap_luma(cfg_swap_luma), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte)
    );

    function automatic logic [15:0] model(int mode, bit sc, bit sl, bit odd, logic [23:0] d);
        int r, g, b, y, c, raw;
        r = sc ? int'(d[7:0]) : int'(d[23:16]);
        g = int'(d[15:8]);
        b = sc ? int'(d[23:16]) : int'(d[7:0]);
        raw = int'(d[9:0]);
        case (mode)
            1: return 16'((r / 8) * 2048 + (g / 4) * 32 + b / 8);
            2: return 16'((r / 8) * 1024 + (g / 8) * 32 + b / 8);
            3: return 16'((r / 16) * 4096 + (g / 16) * 256 + (b / 16) * 16);
            4: return 16'((r / 16) * 256 + (g / 16) * 16 + b / 16);
            5: return 16'((raw / 4) * 256 + raw % 4);
            default: begin
                y = int'(d[23:16]);
                c = (odd ^ sc) ? int'(d[7:0]) : int'(d[15:8]);
                return sl ? 16'(y * 256 + c) : 16'(c * 256 + y);
            end
        endcase
    endfunction

    function automatic string tag_of(int mode, bit sc, bit sl);
        case (mode)
            1: return sc ? "R9" : "R4";
            2: return sc ? "R9" : "R5";
            3: return sc ? "R9" : "R6";
            4: return sc ? "R9" : "R7";
            5: return "R8";
            default: return sl ? "R3" : (sc ? "R2" : "R1");
        endcase
    endfunction

    task automatic send_px(input logic [23:0] d);
        logic [15:0] w;
        string t;
        @(negedge clk);
        in_valid = 1'b1;
        px_data  = d;
        while (!in_ready) @(negedge clk);
        if (!m_odd) begin
            m_mode = int'(cfg_mode);
            m_sc   = cfg_swap_chroma;
            m_sl   = cfg_swap_luma;
        end
        w = model(m_mode, m_sc, m_sl, m_odd, d);
        t = (tag_force != "") ? tag_force : tag_of(m_mode, m_sc, m_sl);
        exp_q.push_back(w[15:8]); tag_q.push_back(t);
        exp_q.push_back(w[7:0]);  tag_q.push_back(t);
        m_odd = !m_odd;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Output stall pattern, changed away from both clock edges.
    always begin
        @(posedge clk);
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // Byte monitor.
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                checks++;
                if (!(out_valid && out_byte == prev_byte))
                    $display("FAIL R11 held byte: valid=%0b byte=%02h expected valid=1 byte=%02h",
                             out_valid, out_byte, prev_byte);
                if (!(out_valid && out_byte == prev_byte)) fails++;
            end
            if (out_valid && !out_ready) begin
                checks++;
                if (in_ready) begin
                    fails++;
                    $display("FAIL R11 in_ready during stall: actual=1 expected=0");
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R11 unexpected byte: actual=%02h expected=none", out_byte);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (out_byte !== e) begin
                        fails++;
                        $display("FAIL %s byte: actual=%02h expected=%02h", t, out_byte, e);
                    end
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_byte  = out_byte;
        end else begin
            stall_prev = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R12 reset state: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end

        // Sweep every mode value against every swap combination.
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                bp_on = ((m + s) % 2) == 1;
                @(negedge clk);
                cfg_mode        = 3'(m);
                cfg_swap_chroma = s[0];
                cfg_swap_luma   = s[1];
                for (int k = 0; k < 16; k++) begin
                    logic [23:0] d;
                    if (k == 0)      d = 24'h000000;
                    else if (k == 1) d = 24'hFFFFFF;
                    else d = {8'(k * 37 + m * 11), 8'(k * 91 + 5), 8'(255 - k * 13)};
                    send_px(d);
                end
            end
        end
        drain();
        bp_on = 0;

        // R10: configuration change inside a pair.
        cfg_mode = 3'd0; cfg_swap_chroma = 0; cfg_swap_luma = 0;
        tag_force = "R10";
        send_px(24'h5A3CC3);
        cfg_mode = 3'd1; cfg_swap_chroma = 1; cfg_swap_luma = 1;
        send_px(24'h81E718);
        send_px(24'h81E718);
        send_px(24'h1234F0);
        drain();

        // R12: reset in the middle of a pair restores first-pixel parity.
        cfg_mode = 3'd0; cfg_swap_chroma = 0; cfg_swap_luma = 0;
        tag_force = "R12";
        send_px(24'h40A0B0);
        drain();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_odd = 0;
        cfg_swap_luma = 1;
        send_px(24'h40A0B0);
        send_px(24'h40A0B0);
        drain();

        finish_run();
    end
endmodule